// File: doc/BRIEF.md
# Outer-Product Tile Multiply-Accumulate Kernel

This block computes one square tile of a matrix product C = A×B. The tile is TQ rows by TQ columns, with TQ a parameter from 1 to 4. A start pulse clears the tile and sets the inner dimension. After that, each accepted input step delivers two vectors of TQ signed elements. The first vector is a slice of one column of A, with one element per tile row. The second is the matching slice of one row of B, with one element per tile column. On each step every tile cell adds the product of its row element and its column element, and all cells do this in the same cycle. Each input step therefore needs 2×TQ×EW bits of operand bandwidth.

When the inner dimension's worth of steps has been accepted, the block stops taking input. It then streams the finished tile out, one cell per cycle in row-major order, and flags the final cell. The surrounding fabric does the operand fetch and decides how the larger matrix is split into tiles. The element width EW is a parameter; 16-bit and 32-bit operands are the intended settings. Each accumulator is wide enough that the largest allowed inner dimension cannot overflow it.

Top module: `outer_tile_mac`

## Requirements
- R1: The parameter TQ (1 to 4) sets the tile size and EW sets the operand width. Each of the vectors `a_vec` and `b_vec` is TQ×EW bits. Element i sits at bits [i×EW +: EW]. Element i of `a_vec` belongs to tile row i, and element j of `b_vec` belongs to tile column j.
- R2: On each accepted step, every cell (i,j) adds a_i×b_j in the same cycle, with both operands read as two's-complement signed values. For TQ=2 the readout order is a0b0, a0b1, a1b0, a1b1.
- R3: Each accumulator is 2×EW+ceil(log2 PMAX) bits. A tile of PMAX steps with extreme operands (for example all operands at the most negative value) gives the exact sum, sign-extended on `out_data`.
- R4: A step is accepted only in a cycle where `in_valid` and `in_ready` are both high. Cycles with `in_valid` low change nothing. The tile closes after exactly `depth` accepted steps.
- R5: `start` is honoured in any state except readout. It clears all cells and latches `depth` (1 to PMAX). `in_ready` goes high from the next cycle. If `start` and `in_valid` are both high in the same cycle, the start wins and the operands are discarded. A start during loading throws away the partial tile.
- R6: Readout begins in the cycle after the final accepted step. `out_valid` stays high for TQ×TQ consecutive cycles, and cell (i,j) appears at position i×TQ+j. `out_last` is high only on the final position.
- R7: `in_ready` is low during readout and when idle. After readout the block returns to idle. A `start` during readout is ignored.
- R8: A start with `depth` = 0 produces a readout of all-zero cells, beginning in the cycle after the start.
- R9: While reset is asserted, and in the first cycle after it, `in_ready`, `out_valid` and `out_last` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Clears the tile and latches depth |
| depth | input | PW = clog2(PMAX+1) | Inner dimension of the tile |
| in_valid | input | 1 | Operand vectors are present |
| in_ready | output | 1 | Kernel accepts a step |
| a_vec | input | TQ×EW | Column slice of A, one element per tile row |
| b_vec | input | TQ×EW | Row slice of B, one element per tile column |
| out_valid | output | 1 | out_data carries a tile cell |
| out_data | output | AW = 2×EW+clog2(PMAX) | Signed cell value, row-major |
| out_last | output | 1 | Final cell of the tile |

## Verification
A cell that is stale, cleared at the wrong time or fed from the wrong row or column shows up as a wrong value at its row-major position. That happens within the readout that immediately follows the faulty tile. A step counter that is off by one shifts the start of readout by a cycle, so `out_valid` fails to match the cycle the bench predicts from `depth`. A control fault that ignores `in_valid`, lets a start through during readout, or fails to discard operands when a start and a step arrive together leaves extra or missing products in the next tile's values. The bench checks these with tiles that contain idle gaps, restarts, extreme operands and zero depth.

// File: rtl/outer_tile_mac.sv
module outer_tile_mac #(
  parameter int TQ   = 2,
  parameter int EW   = 16,
  parameter int PMAX = 64,
  localparam int PW  = $clog2(PMAX + 1),
  localparam int AW  = 2 * EW + $clog2(PMAX),
  localparam int NC  = TQ * TQ,
  localparam int IW  = (NC > 1) ? $clog2(NC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [PW-1:0]      depth,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [TQ*EW-1:0]   a_vec,
  input  logic [TQ*EW-1:0]   b_vec,
  output logic               out_valid,
  output logic [AW-1:0]      out_data,
  output logic               out_last
);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_DRAIN} st_t;

  st_t                  st;
  logic [PW-1:0]        cnt, plen;
  logic [IW-1:0]        idx;
  logic signed [AW-1:0] acc  [NC];
  logic signed [AW-1:0] pext [NC];

  for (genvar i = 0; i < TQ; i++) begin : g_row
    for (genvar j = 0; j < TQ; j++) begin : g_col
      logic signed [2*EW-1:0] prod;
      assign prod = $signed(a_vec[i*EW +: EW]) * $signed(b_vec[j*EW +: EW]);
      assign pext[i*TQ+j] = AW'(prod);
    end
  end

  wire take   = (st == S_LOAD) && in_valid;
  wire honour = start && (st != S_DRAIN);

  assign in_ready  = (st == S_LOAD);
  assign out_valid = (st == S_DRAIN);
  assign out_data  = acc[idx];
  assign out_last  = (st == S_DRAIN) && (idx == IW'(NC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      plen <= '0;
      idx  <= '0;
      for (int k = 0; k < NC; k++) acc[k] <= '0;
    end else if (honour) begin
      for (int k = 0; k < NC; k++) acc[k] <= '0;
      cnt  <= '0;
      plen <= depth;
      idx  <= '0;
      st   <= (depth == '0) ? S_DRAIN : S_LOAD;
    end else if (take) begin
      for (int k = 0; k < NC; k++) acc[k] <= acc[k] + pext[k];
      cnt <= cnt + PW'(1);
      if (cnt + PW'(1) == plen) st <= S_DRAIN;
    end else if (st == S_DRAIN) begin
      if (idx == IW'(NC - 1)) begin
        idx <= '0;
        st  <= S_IDLE;
      end else begin
        idx <= idx + IW'(1);
      end
    end
  end

endmodule

// File: rtl/outer_tile_mac_chk.sv
module outer_tile_mac_chk #(
  parameter int PW = 4,
  parameter int NC = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [PW-1:0] depth,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_last
);

  logic [PW-1:0] seen, want;
  logic [7:0]    dcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= '0;
      want <= '0;
      dcnt <= '0;
    end else begin
      if (start && !out_valid) begin
        seen <= '0;
        want <= depth;
      end else if (in_valid && in_ready) begin
        seen <= seen + PW'(1);
      end
      if (out_valid && !out_last) dcnt <= dcnt + 8'd1;
      else                        dcnt <= '0;
    end
  end

  AST_READY_NOT_IN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n) !(in_ready && out_valid)); // R7
  AST_STEP_COUNT: assert property (@(posedge clk) disable iff (!rst_n) $rose(out_valid) |-> seen == want); // R4
  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n) out_last |-> out_valid); // R6
  AST_DRAIN_UNBROKEN: assert property (@(posedge clk) disable iff (!rst_n) out_valid && !out_last |=> out_valid); // R6
  AST_DRAIN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n) out_last |-> dcnt == 8'(NC - 1)); // R6
  AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n) start && !out_valid && depth != '0 |=> in_ready); // R5
  AST_IDLE_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n) out_last |=> !out_valid && !in_ready); // R7

endmodule

bind outer_tile_mac outer_tile_mac_chk #(.PW(PW), .NC(NC)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .depth(depth), .in_valid(in_valid),
  .in_ready(in_ready), .out_valid(out_valid), .out_last(out_last)
);

// File: tb/tb_outer_tile_mac.sv
module tb_outer_tile_mac;
  localparam int TQ = 3, EW = 16, PMAX = 8;
  localparam int PW = $clog2(PMAX + 1);
  localparam int AW = 2 * EW + $clog2(PMAX);
  localparam int NC = TQ * TQ;

  logic clk = 0, rst_n = 0, start = 0, in_valid = 0;
  logic [PW-1:0] depth = '0;
  logic [TQ*EW-1:0] a_vec = '0, b_vec = '0;
  logic in_ready, out_valid, out_last;
  logic [AW-1:0] out_data;

  outer_tile_mac #(.TQ(TQ), .EW(EW), .PMAX(PMAX)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .depth(depth), .in_valid(in_valid),
    .in_ready(in_ready), .a_vec(a_vec), .b_vec(b_vec), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  int av [PMAX][TQ];
  int bv [PMAX][TQ];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int pick(int mode, int s, int i, bit side);
    case (mode)
      0: return int'($urandom_range(0, 65535)) - 32768;
      1: return -32768;
      2: return side ? -32768 : 32767;
      default: return s * TQ + i + 1 - (side ? 7 : 0);
    endcase
  endfunction

  task automatic do_tile(int p, int mode, bit gaps, bit dirty, bit drain_start);
    for (int s = 0; s < PMAX; s++)
      for (int i = 0; i < TQ; i++) begin
        av[s][i] = pick(mode, s, i, 0);
        bv[s][i] = pick(mode, s, i, 1);
      end
    @(negedge clk);
    start = 1; depth = PW'(p);
    in_valid = dirty; a_vec = {TQ*EW{1'b1}}; b_vec = {TQ{16'h4000}};
    @(negedge clk);
    start = 0; in_valid = 0;
    chk(in_ready == (p != 0), (p != 0) ? "R5" : "R8", "in_ready after start", in_ready, p != 0);
    for (int s = 0; s < p; s++) begin
      if (gaps) begin
        a_vec = {TQ*EW{1'b1}}; b_vec = {TQ*EW{1'b1}};
        @(negedge clk);
      end
      for (int i = 0; i < TQ; i++) begin
        a_vec[i*EW +: EW] = av[s][i][EW-1:0];
        b_vec[i*EW +: EW] = bv[s][i][EW-1:0];
      end
      in_valid = 1;
      @(negedge clk);
      in_valid = 0;
    end
    for (int k = 0; k < NC; k++) begin
      longint e = 0;
      logic signed [AW-1:0] ev;
      for (int s = 0; s < p; s++) e += longint'(av[s][k / TQ]) * longint'(bv[s][k % TQ]);
      ev = e[AW-1:0];
      chk(out_valid == 1, "R6", "out_valid in readout", out_valid, 1);
      chk(out_data == ev, (mode == 1 || mode == 2) ? "R3" : "R2", $sformatf("cell %0d", k),
          longint'($signed(out_data)), longint'(ev));
      chk(out_last == (k == NC - 1), "R6", "out_last", out_last, k == NC - 1);
      chk(in_ready == 0, "R7", "in_ready in readout", in_ready, 0);
      if (drain_start && k == 1) begin start = 1; depth = PW'(5); end
      @(negedge clk);
      start = 0;
    end
    chk(out_valid == 0 && in_ready == 0, "R7", "idle after readout", {out_valid, in_ready}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready == 0 && out_valid == 0 && out_last == 0, "R9", "outputs in reset",
        {in_ready, out_valid, out_last}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(in_ready == 0 && out_valid == 0 && out_last == 0, "R9", "outputs after reset",
        {in_ready, out_valid, out_last}, 0);
    // R1 R2: small sequential pattern checks index mapping
    do_tile(1, 3, 0, 0, 0);
    do_tile(3, 3, 0, 0, 0);
    // R3: extreme operands over PMAX steps
    do_tile(PMAX, 1, 0, 0, 0);
    do_tile(PMAX, 2, 0, 0, 0);
    // R4: idle gaps with garbage data
    do_tile(5, 0, 1, 0, 0);
    // R5: restart mid-load discards partial tile, start beats in_valid
    @(negedge clk);
    start = 1; depth = PW'(4);
    @(negedge clk);
    start = 0; in_valid = 1; a_vec = {TQ{16'h0123}}; b_vec = {TQ{16'h0456}};
    repeat (2) @(negedge clk);
    in_valid = 0;
    do_tile(4, 0, 0, 1, 0);
    // R7: start during readout is ignored
    do_tile(2, 0, 0, 0, 1);
    repeat (2) @(negedge clk);
    chk(in_ready == 0 && out_valid == 0, "R7", "start in readout ignored", {in_ready, out_valid}, 0);
    // R8: zero depth
    do_tile(0, 0, 0, 0, 0);
    // sweep of depths with random operands
    for (int p = 1; p <= PMAX; p++) do_tile(p, 0, p % 2, 0, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule